// File: doc/BRIEF.md
# Host Memory DMA Port

This block lets an external host reach the on-chip program and data memories without involving the core. One 16-bit bus carries both addresses and data. The host first presents an address word and pulses the address-latch strobe. The falling edge of that strobe captures a 14-bit word address and a memory-type bit. After that, each select-plus-read or select-plus-write cycle moves one bus word, and the captured address steps forward by itself, so a block transfer needs only its start address.

The host strobes arrive with no timing relation to the core clock. They pass through a synchroniser and are followed by a single core cycle of memory access. While a request is in flight, acknowledge is held low. Program words are 24 bits wide and cross the bus in two halves. Data-memory writes that land in the control-register window are dropped. The core can load the address and type register itself. In host-boot mode, a hold output keeps the core stalled until program word 0 has been written through the port.

Top module: `hostdma_port`

## Requirements
- R1: After reset, `host_ack` is 1, no memory request is issued, and `core_hold` equals `boot_host`. The access address is 0 and targets data memory.
- R2: When the synchronised `host_alatch` falls, the address register loads `host_ad_i[13:0]` and the type bit loads `host_ad_i[14]` (1 = program memory, 0 = data memory). Bit 15 has no effect. Any half-done program-word phase is cleared.
- R3: `host_ack` drops as soon as `host_cs` is high together with `host_rd` or `host_wr`. It returns high after exactly SYNC_STAGES+2 rising clock edges. Each memory access is a single-cycle `mem_req` pulse, and `host_ack` is low during that pulse.
- R4: The address increments by one after every completed data-memory transfer. For program memory it increments after the second half of each word. It wraps from 0x3FFF to 0x0000.
- R5: A data-memory write stores `host_ad_i[15:0]` at the current address. A data-memory read returns bits 15:0 of the memory word on `host_ad_o`.
- R6: A program-memory write takes two host writes. The first carries bits 23:8 and makes no memory access. The second carries bits 7:0 in `host_ad_i[7:0]` and writes the full 24-bit word with one access.
- R7: A program-memory read takes two host reads. The first performs the memory read and returns bits 23:8. The second makes no access and returns bits 7:0 in `host_ad_o[7:0]`, with zeros in bits 15:8.
- R8: A data-memory write to an address at or above CTRL_BASE (default 0x3FE0) makes no memory write. The address still increments.
- R9: A `core_ld` pulse loads `core_ld_addr` and `core_ld_pm` into the address and type register and clears the program-word phase. A host latch in the same cycle takes priority.
- R10: With `boot_host` at 1, `core_hold` stays high until a program-memory write to address 0 completes. Data-memory writes to address 0, and program-memory writes to other addresses, do not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| host_ad_i | input | 16 | Host address/data bus, inbound |
| host_ad_o | output | 16 | Host read data, outbound |
| host_alatch | input | 1 | Address latch strobe, captured on its falling edge |
| host_cs | input | 1 | Host select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_ack | output | 1 | Acknowledge, low while a request is pending |
| core_ld | input | 1 | Core load of the address and type register |
| core_ld_addr | input | 14 | Address loaded by the core |
| core_ld_pm | input | 1 | Type loaded by the core (1 = program memory) |
| boot_host | input | 1 | Host-boot mode select |
| core_hold | output | 1 | Stalls the core until program word 0 is written |
| mem_req | output | 1 | Single-cycle memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_is_pm | output | 1 | Access targets program memory |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 24 | Write data (data memory uses bits 15:0) |
| mem_rdata | input | 24 | Read data, valid in the cycle of `mem_req` |

## Verification
The bench builds the port with its default parameters: a 14-bit address, a 16-bit bus, 24-bit program words, a two-stage synchroniser and a control window starting at 0x3FE0. These values make the exact four-edge acknowledge latency a fixed number the bench can predict. They also put the address wrap at 0x3FFF and the protected window at the top of the data space within a few transfers. The bench sweeps contiguous blocks of data and program words, writing them and reading them back. Expected words are computed from the sweep index, and the number of memory strobes per host transfer is counted to catch split-word errors.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_ACC  = 2'd1,
      XS_REL  = 2'd2
   } xfer_st_e;
endpackage

// File: rtl/hdp_sync.sv
module hdp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hdp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hdp_addr.sv
module hdp_addr #(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alatch_s,
   input  logic [ADDR_W:0]   bus_i,
   input  logic              core_ld,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              core_pm,
   input  logic              incr,
   output logic [ADDR_W-1:0] addr,
   output logic              is_pm,
   output logic              reload
);
   logic alatch_q;
   logic fall;

   assign fall   = alatch_q & ~alatch_s;
   assign reload = fall | core_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alatch_q <= 1'b0;
         addr     <= '0;
         is_pm    <= 1'b0;
      end else begin
         alatch_q <= alatch_s;
         if (fall) begin
            addr  <= bus_i[ADDR_W-1:0];
            is_pm <= bus_i[ADDR_W];
         end else if (core_ld) begin
            addr  <= core_addr;
            is_pm <= core_pm;
         end else if (incr) begin
            addr <= addr + 1'b1;
         end
      end
   end

   a_r4_addr_step : assert property (@(posedge clk) disable iff (!rst_n)
      (incr && !reload) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

   a_r2_latch_capture : assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (addr == $past(bus_i[ADDR_W-1:0]) && is_pm == $past(bus_i[ADDR_W])));

   a_r9_core_load : assert property (@(posedge clk) disable iff (!rst_n)
      (core_ld && !fall) |=> (addr == $past(core_addr) && is_pm == $past(core_pm)));
endmodule

// File: rtl/hdp_xfer.sv
module hdp_xfer
   import hdp_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int BUS_W     = 16,
   parameter int PM_W      = 24,
   parameter int CTRL_BASE = 'h3FE0,
   parameter bit PROTECT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_raw,
   input  logic              req_s,
   input  logic              is_wr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_pm,
   input  logic              phase_clr,
   input  logic [PM_W-1:0]   mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PM_W-1:0]   mem_wdata,
   output logic [BUS_W-1:0]  dout,
   output logic              ack,
   output logic              incr
);
   localparam int LO_W = PM_W - BUS_W;
   localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_BASE);

   xfer_st_e         st;
   logic             phase;
   logic [BUS_W-1:0] stage_hi;
   logic [LO_W-1:0]  stage_lo;
   logic             blocked;
   logic             in_acc;
   logic             needs_mem;

   generate
      if (PROTECT) begin : g_protect
         assign blocked = ~is_pm & is_wr & (addr >= CTRL_LIM);
      end else begin : g_open
         assign blocked = 1'b0;
      end
   endgenerate

   assign in_acc    = (st == XS_ACC);
   assign needs_mem = is_pm ? (is_wr ? phase : ~phase) : ~blocked;
   assign mem_req   = in_acc & needs_mem;
   assign mem_we    = is_wr;
   assign mem_wdata = is_pm ? {stage_hi, wdata[LO_W-1:0]} : {{LO_W{1'b0}}, wdata};
   assign incr      = in_acc & (~is_pm | phase);
   assign ack       = (st == XS_REL) | ((st == XS_IDLE) & ~req_raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= XS_IDLE;
         phase    <= 1'b0;
         stage_hi <= '0;
         stage_lo <= '0;
         dout     <= '0;
      end else begin
         case (st)
            XS_IDLE: if (req_s) st <= XS_ACC;
            XS_ACC:  st <= XS_REL;
            XS_REL:  if (!req_s) st <= XS_IDLE;
            default: st <= XS_IDLE;
         endcase
         if (phase_clr)          phase <= 1'b0;
         else if (in_acc && is_pm) phase <= ~phase;
         if (in_acc && is_wr && is_pm && !phase) stage_hi <= wdata;
         if (in_acc && !is_wr) begin
            if (!is_pm)     dout <= mem_rdata[BUS_W-1:0];
            else if (phase) dout <= {{(BUS_W-LO_W){1'b0}}, stage_lo};
            else begin
               dout     <= mem_rdata[PM_W-1:LO_W];
               stage_lo <= mem_rdata[LO_W-1:0];
            end
         end
      end
   end

   a_r3_single_access : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   a_r3_ack_low_on_access : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ack);

   a_r8_no_ctrl_write : assert property (@(posedge clk) disable iff (!rst_n)
      (PROTECT && mem_req && mem_we && !is_pm) |-> (addr < CTRL_LIM));

   a_r6_first_half_silent : assert property (@(posedge clk) disable iff (!rst_n)
      (in_acc && is_pm && is_wr && !phase) |-> !mem_req);
endmodule

// File: rtl/hostdma_port.sv
module hostdma_port #(
   parameter int ADDR_W      = 14,
   parameter int BUS_W       = 16,
   parameter int PM_W        = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_BASE   = 'h3FE0,
   parameter bit PROTECT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  host_ad_i,
   output logic [BUS_W-1:0]  host_ad_o,
   input  logic              host_alatch,
   input  logic              host_cs,
   input  logic              host_rd,
   input  logic              host_wr,
   output logic              host_ack,
   input  logic              core_ld,
   input  logic [ADDR_W-1:0] core_ld_addr,
   input  logic              core_ld_pm,
   input  logic              boot_host,
   output logic              core_hold,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_is_pm,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PM_W-1:0]   mem_wdata,
   input  logic [PM_W-1:0]   mem_rdata
);
   generate
      if (ADDR_W + 1 > BUS_W) begin : g_bad_addr
         $error("hostdma_port: address plus type bit must fit the bus");
      end
      if (PM_W <= BUS_W || PM_W - BUS_W > BUS_W) begin : g_bad_pm
         $error("hostdma_port: program word must need exactly two bus transfers");
      end
      if (CTRL_BASE >= (1 << ADDR_W)) begin : g_bad_ctrl
         $error("hostdma_port: CTRL_BASE outside the address space");
      end
   endgenerate

   logic       req_raw;
   logic [1:0] sync_q;
   logic       alatch_s;
   logic       req_s;
   logic       is_pm;
   logic       reload;
   logic       incr;
   logic       released;

   assign req_raw = host_cs & (host_rd | host_wr);

   hdp_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_alatch, req_raw}),
      .q     (sync_q)
   );
   assign alatch_s = sync_q[1];
   assign req_s    = sync_q[0];

   hdp_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .alatch_s  (alatch_s),
      .bus_i     (host_ad_i[ADDR_W:0]),
      .core_ld   (core_ld),
      .core_addr (core_ld_addr),
      .core_pm   (core_ld_pm),
      .incr      (incr),
      .addr      (mem_addr),
      .is_pm     (is_pm),
      .reload    (reload)
   );

   hdp_xfer #(
      .ADDR_W    (ADDR_W),
      .BUS_W     (BUS_W),
      .PM_W      (PM_W),
      .CTRL_BASE (CTRL_BASE),
      .PROTECT   (PROTECT)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_raw   (req_raw),
      .req_s     (req_s),
      .is_wr     (host_wr),
      .wdata     (host_ad_i),
      .addr      (mem_addr),
      .is_pm     (is_pm),
      .phase_clr (reload),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .dout      (host_ad_o),
      .ack       (host_ack),
      .incr      (incr)
   );

   assign mem_is_pm = is_pm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) released <= 1'b0;
      else if (mem_req && mem_we && is_pm && mem_addr == '0) released <= 1'b1;
   end

   assign core_hold = boot_host & ~released;

   a_r10_release_cause : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(core_hold) && boot_host) |->
         $past(mem_req && mem_we && mem_is_pm && mem_addr == '0));

   a_r10_stays_released : assert property (@(posedge clk) disable iff (!rst_n)
      (!core_hold && boot_host && $past(boot_host)) |=> (!core_hold || !boot_host));
endmodule

// File: tb/hostdma_port_tb.sv
module hostdma_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_ad_i = '0;
   logic [15:0] host_ad_o;
   logic        host_alatch = 1'b0, host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic        host_ack;
   logic        core_ld = 1'b0;
   logic [13:0] core_ld_addr = '0;
   logic        core_ld_pm = 1'b0;
   logic        boot_host = 1'b1;
   logic        core_hold;
   logic        mem_req, mem_we, mem_is_pm;
   logic [13:0] mem_addr;
   logic [23:0] mem_wdata;
   logic [23:0] mem_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   hostdma_port u_dut (
      .clk(clk), .rst_n(rst_n), .host_ad_i(host_ad_i), .host_ad_o(host_ad_o),
      .host_alatch(host_alatch), .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
      .host_ack(host_ack), .core_ld(core_ld), .core_ld_addr(core_ld_addr),
      .core_ld_pm(core_ld_pm), .boot_host(boot_host), .core_hold(core_hold),
      .mem_req(mem_req), .mem_we(mem_we), .mem_is_pm(mem_is_pm), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // memory model, 256 words per space indexed by the low address byte
   logic [23:0] pm_m [256];
   logic [15:0] dm_m [256];
   int          req_cnt = 0;
   int          wr_cnt  = 0;
   logic [13:0] last_addr = '0;
   logic        last_pm = 1'b0;

   always_comb mem_rdata = mem_is_pm ? pm_m[mem_addr[7:0]] : {8'h00, dm_m[mem_addr[7:0]]};

   always @(posedge clk) begin
      if (rst_n && mem_req) begin
         req_cnt   = req_cnt + 1;
         last_addr = mem_addr;
         last_pm   = mem_is_pm;
         if (mem_we) begin
            wr_cnt = wr_cnt + 1;
            if (mem_is_pm) pm_m[mem_addr[7:0]] = mem_wdata;
            else           dm_m[mem_addr[7:0]] = mem_wdata[15:0];
         end
      end
   end

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic latch(input logic [15:0] w);
      @(negedge clk);
      host_ad_i   = w;
      host_alatch = 1'b1;
      repeat (4) @(negedge clk);
      host_alatch = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic xfer(input bit wr, input logic [15:0] wd, output logic [15:0] rd,
                       output int lat, output bit ack_dropped);
      @(negedge clk);
      host_ad_i = wd;
      host_cs   = 1'b1;
      host_wr   = wr;
      host_rd   = ~wr;
      #1 ack_dropped = ~host_ack;
      lat = 0;
      while (!host_ack && lat < 50) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      rd = host_ad_o;
      host_cs = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      int          lat;
      bit          dropped;
      int          r0, w0;
      for (int i = 0; i < 256; i++) begin
         dm_m[i] = 16'hC300 ^ 16'(i * 37);
         pm_m[i] = 24'h5A0000 ^ 24'(i * 613);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(host_ack == 1'b1, "R1 ack after reset", 32'(host_ack), 1);
      chk(core_hold == 1'b1, "R1 hold equals boot mode", 32'(core_hold), 1);
      chk(mem_req == 1'b0, "R1 no request in reset", 32'(mem_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1/R3: read at reset address, exact latency
      xfer(1'b0, 16'h0, rd, lat, dropped);
      chk(dropped, "R3 ack drops on request", 32'(dropped), 1);
      chk(lat == 4, "R3 ack latency", 32'(lat), 4);
      chk(last_addr == 14'h0 && !last_pm, "R1 reset address data space", 32'({last_pm, last_addr}), 0);
      chk(rd == dm_m[0], "R5 read at reset address", 32'(rd), 32'(dm_m[0]));

      // R2/R4/R5: data write sweep, bit 15 set and ignored
      latch(16'h8010);
      for (int i = 0; i < 16; i++) begin
         w0 = wr_cnt;
         xfer(1'b1, 16'h1000 + 16'(i * 16'h0101), rd, lat, dropped);
         chk(wr_cnt == w0 + 1, "R3 one write access", 32'(wr_cnt - w0), 1);
         chk(last_addr == 14'(16 + i) && !last_pm, "R2 R4 write address", 32'({last_pm, last_addr}), 32'(16 + i));
      end
      latch(16'h0010);
      for (int i = 0; i < 16; i++) begin
         xfer(1'b0, 16'h0, rd, lat, dropped);
         chk(rd == 16'h1000 + 16'(i * 16'h0101), "R5 read back", 32'(rd), 32'(16'h1000 + 16'(i * 16'h0101)));
      end

      // R6: program word writes at 0x20
      latch(16'h4020);
      for (int i = 0; i < 8; i++) begin
         logic [23:0] v;
         v  = 24'hA10000 + 24'(i * 24'h010203);
         r0 = req_cnt;
         xfer(1'b1, v[23:8], rd, lat, dropped);
         chk(req_cnt == r0, "R6 first half no access", 32'(req_cnt - r0), 0);
         xfer(1'b1, {8'hEE, v[7:0]}, rd, lat, dropped);
         chk(req_cnt == r0 + 1 && last_pm && last_addr == 14'(32 + i), "R6 second half access",
             32'({last_pm, last_addr}), 32'({1'b1, 14'(32 + i)}));
         chk(pm_m[32 + i] == v, "R6 stored word", 32'(pm_m[32 + i]), 32'(v));
      end
      chk(core_hold == 1'b1, "R10 hold after other program writes", 32'(core_hold), 1);

      // R7: program word reads
      latch(16'h4020);
      for (int i = 0; i < 8; i++) begin
         logic [23:0] v;
         v  = 24'hA10000 + 24'(i * 24'h010203);
         r0 = req_cnt;
         xfer(1'b0, 16'h0, rd, lat, dropped);
         chk(rd == v[23:8] && req_cnt == r0 + 1, "R7 upper half", 32'(rd), 32'(v[23:8]));
         xfer(1'b0, 16'h0, rd, lat, dropped);
         chk(rd == {8'h00, v[7:0]} && req_cnt == r0 + 1, "R7 lower half", 32'(rd), 32'(v[7:0]));
      end

      // R4: wrap
      latch(16'h3FFF);
      xfer(1'b0, 16'h0, rd, lat, dropped);
      chk(rd == dm_m[8'hFF], "R4 read top address", 32'(rd), 32'(dm_m[8'hFF]));
      xfer(1'b0, 16'h0, rd, lat, dropped);
      chk(last_addr == 14'h0, "R4 wrap to zero", 32'(last_addr), 0);

      // R8: control window protection
      latch(16'h3FE0);
      w0 = wr_cnt;
      xfer(1'b1, 16'hDEAD, rd, lat, dropped);
      chk(wr_cnt == w0, "R8 write dropped", 32'(wr_cnt - w0), 0);
      xfer(1'b0, 16'h0, rd, lat, dropped);
      chk(last_addr == 14'h3FE1, "R8 address still steps", 32'(last_addr), 32'h3FE1);
      chk(rd == dm_m[8'hE1], "R8 read in window allowed", 32'(rd), 32'(dm_m[8'hE1]));

      // R9: core load
      @(negedge clk);
      core_ld_addr = 14'h0040; core_ld_pm = 1'b0; core_ld = 1'b1;
      @(negedge clk);
      core_ld = 1'b0;
      xfer(1'b0, 16'h0, rd, lat, dropped);
      chk(last_addr == 14'h0040 && !last_pm && rd == dm_m[8'h40], "R9 core loaded address",
          32'({last_pm, last_addr}), 32'h40);
      @(negedge clk);
      core_ld_addr = 14'h0021; core_ld_pm = 1'b1; core_ld = 1'b1;
      @(negedge clk);
      core_ld = 1'b0;
      xfer(1'b0, 16'h0, rd, lat, dropped);
      chk(last_pm && last_addr == 14'h21 && rd == pm_m[8'h21][23:8], "R9 core loaded program type",
          32'({last_pm, last_addr}), 32'h4021);

      // R10: boot release
      latch(16'h0000);
      xfer(1'b1, 16'h1234, rd, lat, dropped);
      chk(core_hold == 1'b1, "R10 data write to 0 keeps hold", 32'(core_hold), 1);
      latch(16'h4000);
      xfer(1'b1, 16'hBEEF, rd, lat, dropped);
      chk(core_hold == 1'b1, "R10 half word keeps hold", 32'(core_hold), 1);
      xfer(1'b1, 16'h0042, rd, lat, dropped);
      chk(core_hold == 1'b0, "R10 released", 32'(core_hold), 0);
      chk(pm_m[0] == 24'hBEEF42, "R6 boot word stored", 32'(pm_m[0]), 32'hBEEF42);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule